// File: doc/BRIEF.md
# Pipelined Burst SRAM With Zero Bus Turnaround

This block is a synthesizable behavioural model of a synchronous pipelined static RAM that holds 36-bit words. Each word is split into four 9-bit byte lanes, and each lane carries eight data bits plus one parity bit. For simulation the depth is reduced to a parameter, by default 256 words. A command is taken on every enabled clock edge. A command is one of three things: a load with a fresh external address, an advance of the internal two-bit burst counter, or a deselect. Reads and writes can be mixed in any order with no idle cycles between them.

Write data is taken two enabled edges after its address. Read data is presented in the cycle that ends at the second enabled edge after its address. Both directions therefore occupy the same data-bus slot, so a read can follow a write, or a write a read, without a turnaround gap. A read whose address matches a write that is still in flight returns the pending data, merged lane by lane. When the clock enable is low, the whole pipeline freezes. The output enable is combinational and only gates the bus drive.

Top module: `pipe_burst_sram`

## Requirements
- R1: A write updates only the lanes whose `byte_sel` bit is 1. Bit i of `byte_sel` selects word bits [9i+8:9i]. A write with `byte_sel` = 0 leaves the word unchanged.
- R2: A read issued at enabled edge E0 shows its word on `dout` from enabled edge E1 until enabled edge E2. A write issued at E0 takes `din` at E2.
- R3: Reads and writes may be issued on every enabled edge in any mix. A read returns the word including every earlier-issued write, and a write that commits at the same edge as the read's output is forwarded lane by lane.
- R4: While `clk_en` is 0, every other synchronous input is ignored. `dout`, `dout_oe`, the burst state and the memory all hold.
- R5: A load (`advance` = 0) starts an access only when `chip_sel` = 3'b111. Any other value is a deselect: it produces no read slot and no write.
- R6: With `advance` = 1, the block issues the next burst address with the same direction as the command that loaded the burst. `wr_en` and `chip_sel` are ignored on an advance. The two-bit counter wraps after four beats. An advance after a deselect is again a deselect.
- R7: Burst order: with INTERLEAVE = 1 the low two address bits are start XOR count. With INTERLEAVE = 0 they are (start + count) mod 4. The upper address bits stay fixed.
- R8: `dout_oe` is 1 only in a read's output slot and only while `out_en` is 1. `out_en` acts without waiting for a clock edge.
- R9: After reset, no read slot is active, `dout_oe` is 0 and no burst is active, so an advance issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset of control state, active low |
| clk_en | input | 1 | Clock enable; 0 freezes the pipeline |
| chip_sel | input | 3 | Chip enables; all must be 1 for a load to start an access |
| advance | input | 1 | 0 = load `addr`, 1 = advance the burst counter |
| wr_en | input | 1 | 1 = write, 0 = read (sampled on a load) |
| byte_sel | input | LANES (4) | Per-lane write select |
| addr | input | ADDR_W (8) | Word address |
| out_en | input | 1 | Asynchronous output enable |
| din | input | LANES*LANE_W (36) | Write data, bus input side |
| dout | output | LANES*LANE_W (36) | Read data, bus output side |
| dout_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume that reset is held low until the first clock and that every control input has a known value at each rising edge. In particular, `clk_en`, `advance` and `chip_sel` are never left undriven, because a deselect and a stall are judged from them. The stimulus changes inputs only on falling edges and drives defined values at all times, including garbage commands during stalls. It also fills every word before any read, so each read result has a known expected value.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;
   localparam int unsigned BURST_BEATS = 4;
endpackage

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
   import pbs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter bit          INTERLEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              advance,
   input  logic              sel_all,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] ext_addr,
   output op_e               issue_op,
   output logic [ADDR_W-1:0] issue_addr
);
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic [1:0]        cnt_nx;
   logic [1:0]        lo_nx;
   op_e               bop_q;

   assign cnt_nx = cnt_q + 2'd1;

   generate
      if (INTERLEAVE) begin : g_ilv
         assign lo_nx = base_q[1:0] ^ cnt_nx;
      end else begin : g_lin
         assign lo_nx = base_q[1:0] + cnt_nx;
      end
   endgenerate

   always_comb begin
      if (!advance) begin
         issue_op   = sel_all ? (wr_req ? OP_WR : OP_RD) : OP_NONE;
         issue_addr = ext_addr;
      end else begin
         issue_op   = bop_q;
         issue_addr = {base_q[ADDR_W-1:2], lo_nx};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         bop_q  <= OP_NONE;
      end else if (en) begin
         if (!advance) begin
            base_q <= ext_addr;
            cnt_q  <= '0;
            bop_q  <= issue_op;
         end else if (bop_q != OP_NONE) begin
            cnt_q <= cnt_nx;
         end
      end
   end

   AST_BURST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && advance) |=> (base_q == $past(base_q))) else $error("base moved on advance"); // R6
endmodule

// File: rtl/pbs_store.sv
module pbs_store #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                     clk,
   input  logic                     en,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [LANES-1:0]         wr_lanes,
   input  logic [LANES*LANE_W-1:0]  wr_word,
   output logic [LANES*LANE_W-1:0]  rd_word
);
   localparam int unsigned WORD_W = LANES * LANE_W;
   localparam int unsigned DEPTH  = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];
   logic              hit;

   assign hit = wr_en && (wr_addr == rd_addr);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign rd_word[l*LANE_W +: LANE_W] = (hit && wr_lanes[l])
                                             ? wr_word[l*LANE_W +: LANE_W]
                                             : mem[rd_addr][l*LANE_W +: LANE_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (en && wr_en) begin
         for (int l = 0; l < LANES; l++) begin
            if (wr_lanes[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_word[l*LANE_W +: LANE_W];
         end
      end
   end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
   import pbs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned LANES      = 4,
   parameter int unsigned LANE_W     = 9,
   parameter int unsigned N_SEL      = 3,
   parameter bit          INTERLEAVE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clk_en,
   input  logic [N_SEL-1:0]         chip_sel,
   input  logic                     advance,
   input  logic                     wr_en,
   input  logic [LANES-1:0]         byte_sel,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     out_en,
   input  logic [LANES*LANE_W-1:0]  din,
   output logic [LANES*LANE_W-1:0]  dout,
   output logic                     dout_oe
);
   localparam int unsigned WORD_W = LANES * LANE_W;

   generate
      if (ADDR_W < 3 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must be 3..12");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("LANES and LANE_W must be at least 1");
      end
      if (N_SEL < 1) begin : g_bad_sel
         $error("N_SEL must be at least 1");
      end
   endgenerate

   op_e               iss_op;
   logic [ADDR_W-1:0] iss_addr;
   op_e               s1_op;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_lanes;
   logic              s2_wr;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_lanes;
   logic              rd_slot_q;
   logic [WORD_W-1:0] dout_q;
   logic [WORD_W-1:0] fwd_word;

   pbs_burst_seq #(.ADDR_W(ADDR_W), .INTERLEAVE(INTERLEAVE)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(clk_en), .advance(advance),
      .sel_all(&chip_sel), .wr_req(wr_en), .ext_addr(addr),
      .issue_op(iss_op), .issue_addr(iss_addr)
   );

   pbs_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk(clk), .en(clk_en), .rd_addr(s1_addr),
      .wr_en(s2_wr), .wr_addr(s2_addr), .wr_lanes(s2_lanes), .wr_word(din),
      .rd_word(fwd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op     <= OP_NONE;
         s1_addr   <= '0;
         s1_lanes  <= '0;
         s2_wr     <= 1'b0;
         s2_addr   <= '0;
         s2_lanes  <= '0;
         rd_slot_q <= 1'b0;
         dout_q    <= '0;
      end else if (clk_en) begin
         s1_op     <= iss_op;
         s1_addr   <= iss_addr;
         s1_lanes  <= byte_sel;
         s2_wr     <= (s1_op == OP_WR);
         s2_addr   <= s1_addr;
         s2_lanes  <= s1_lanes;
         rd_slot_q <= (s1_op == OP_RD);
         if (s1_op == OP_RD) dout_q <= fwd_word;
      end
   end

   assign dout    = dout_q;
   assign dout_oe = rd_slot_q & out_en;

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(dout) && $stable(rd_slot_q))) else $error("stall moved output"); // R4
   AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !advance && !(&chip_sel)) |=> (s1_op == OP_NONE)) else $error("deselect issued"); // R5
   AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s1_op == OP_RD) |=> rd_slot_q) else $error("read slot missing"); // R2
   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && advance && s1_op != OP_NONE) |=>
         (s1_op == $past(s1_op) && s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])
          && s1_addr[1:0] != $past(s1_addr[1:0]))) else $error("burst step wrong"); // R6
   AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> rd_slot_q) else $error("drive outside slot"); // R8
endmodule

// File: tb/pipe_burst_sram_test.sv
module pipe_burst_sram_test;
   localparam int unsigned AW  = 8;
   localparam int unsigned LN  = 4;
   localparam int unsigned LW  = 9;
   localparam int unsigned WW  = LN * LW;
   localparam bit          ILV = 1'b1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b0;
   logic [2:0]    chip_sel = '0;
   logic          advance = 1'b0;
   logic          wr_en = 1'b0;
   logic [LN-1:0] byte_sel = '0;
   logic [AW-1:0] addr = '0;
   logic          out_en = 1'b1;
   logic [WW-1:0] din = '0;
   logic [WW-1:0] dout;
   logic          dout_oe;

   always #10 clk = ~clk;

   pipe_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .N_SEL(3), .INTERLEAVE(ILV)) uut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel(chip_sel), .advance(advance),
      .wr_en(wr_en), .byte_sel(byte_sel), .addr(addr), .out_en(out_en), .din(din),
      .dout(dout), .dout_oe(dout_oe)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [WW-1:0] ref_mem [1 << AW];
   int            p1_op = 0, p2_op = 0, b_op = 0;
   logic [AW-1:0] p1_a = '0, p2_a = '0, b_base = '0;
   logic [LN-1:0] p1_be = '0, p2_be = '0;
   logic [1:0]    b_cnt = '0;
   bit            exp_slot = 1'b0;
   logic [WW-1:0] exp_dout = '0;
   int unsigned   seed;

   function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw, logic [LN-1:0] be);
      logic [WW-1:0] r = old;
      for (int l = 0; l < LN; l++) if (be[l]) r[l*LW +: LW] = nw[l*LW +: LW];
      return r;
   endfunction

   function automatic logic [1:0] order_lo(logic [1:0] s, logic [1:0] c);
      return ILV ? (s ^ c) : (s + c);
   endfunction

   task automatic check(bit ok, string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(bit en, bit adv, logic [2:0] cs, bit wr, logic [LN-1:0] be,
                       logic [AW-1:0] a, string tag);
      logic [WW-1:0] dv;
      int            iop;
      logic [AW-1:0] ia;
      dv = WW'({$urandom(), $urandom()});
      clk_en = en; advance = adv; chip_sel = cs; wr_en = wr; byte_sel = be; addr = a; din = dv;
      @(posedge clk);
      if (en) begin
         if (p2_op == 2) ref_mem[p2_a] = merge(ref_mem[p2_a], dv, p2_be);
         exp_slot = (p1_op == 1);
         if (p1_op == 1) exp_dout = ref_mem[p1_a];
         if (!adv) begin
            iop = (cs == 3'b111) ? (wr ? 2 : 1) : 0;
            ia = a; b_base = a; b_cnt = 2'd0; b_op = iop;
         end else if (b_op != 0) begin
            b_cnt = b_cnt + 2'd1;
            iop = b_op;
            ia = {b_base[AW-1:2], order_lo(b_base[1:0], b_cnt)};
         end else begin
            iop = 0; ia = a;
         end
         p2_op = p1_op; p2_a = p1_a; p2_be = p1_be;
         p1_op = iop;   p1_a = ia;   p1_be = be;
      end
      @(negedge clk);
      check(dout_oe === (exp_slot && out_en), {tag, " bus drive"}, WW'(dout_oe), WW'(exp_slot && out_en));
      if (exp_slot) check(dout === exp_dout, {tag, " read data"}, dout, exp_dout);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 3'b000, 1'b0, '0, '0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      seed = $urandom(32'h1350_5eed);
      repeat (3) @(negedge clk);
      check(dout_oe === 1'b0, "R9 reset drive", WW'(dout_oe), '0);
      rst_n = 1'b1;
      // R9: advance with no burst issues nothing
      tick(1'b1, 1'b1, 3'b111, 1'b0, '1, 8'h00, "R9 idle advance");
      tick(1'b1, 1'b1, 3'b111, 1'b0, '1, 8'h00, "R9 idle advance");
      idle(2, "R9 after advance");

      // R2: fill every word back to back
      for (int i = 0; i < (1 << AW); i++) tick(1'b1, 1'b0, 3'b111, 1'b1, '1, AW'(i), "R2 fill");
      idle(2, "R2 fill flush");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '1, 8'h05, "R2 read issue");
      tick(1'b1, 1'b0, 3'b000, 1'b0, '0, 8'h00, "R2 read slot");
      idle(2, "R2 flush");

      // R3: forwarding of in-flight writes, lane merged
      tick(1'b1, 1'b0, 3'b111, 1'b1, 4'b0101, 8'h10, "R3 write");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h10, "R3 read after write");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h10, "R3 read again");
      tick(1'b1, 1'b0, 3'b111, 1'b1, 4'b0011, 8'h11, "R3 write lo");
      tick(1'b1, 1'b0, 3'b111, 1'b1, 4'b1100, 8'h11, "R3 write hi");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h11, "R3 read merged");
      idle(3, "R3 flush");

      // R1: lane selects, including none
      tick(1'b1, 1'b0, 3'b111, 1'b1, 4'b0001, 8'h20, "R1 one lane");
      tick(1'b1, 1'b0, 3'b111, 1'b1, 4'b0000, 8'h21, "R1 no lane");
      tick(1'b1, 1'b0, 3'b111, 1'b1, 4'b1000, 8'h22, "R1 top lane");
      idle(2, "R1 flush");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h20, "R1 read");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h21, "R1 read");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h22, "R1 read");
      idle(2, "R1 flush");

      // R6/R7: read burst with wrap; garbage wr/cs on advance
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h1E, "R7 burst load");
      for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 3'b000, 1'b1, '1, 8'hFF, "R6 burst advance");
      idle(2, "R7 flush");
      // R7: write burst then read it back as a burst
      tick(1'b1, 1'b0, 3'b111, 1'b1, '1, 8'h41, "R7 wburst load");
      for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 3'b000, 1'b0, LN'($urandom()), 8'h00, "R6 wburst advance");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h41, "R7 rburst load");
      for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 3'b111, 1'b1, '1, 8'h00, "R7 rburst advance");
      idle(2, "R7 flush");

      // R4: stall with a read in flight and with a write pending
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h41, "R4 read");
      for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 3'b111, 1'b1, '1, 8'h41, "R4 stall");
      tick(1'b1, 1'b0, 3'b111, 1'b1, 4'b0110, 8'h50, "R4 write");
      tick(1'b1, 1'b0, 3'b000, 1'b0, '0, 8'h00, "R4 gap");
      for (int i = 0; i < 2; i++) tick(1'b0, 1'b1, 3'b111, 1'b1, '1, 8'h50, "R4 stall write");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h50, "R4 read back");
      idle(2, "R4 flush");

      // R5: partial chip select is a deselect, also through advances
      tick(1'b1, 1'b0, 3'b011, 1'b1, '1, 8'h60, "R5 deselect");
      tick(1'b1, 1'b1, 3'b111, 1'b1, '1, 8'h60, "R5 deselect advance");
      tick(1'b1, 1'b1, 3'b111, 1'b0, '1, 8'h60, "R5 deselect advance");
      tick(1'b1, 1'b0, 3'b110, 1'b0, '1, 8'h61, "R5 deselect read");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h60, "R5 unchanged");
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h61, "R5 unchanged");
      idle(2, "R5 flush");

      // R8: output enable acts between clock edges
      tick(1'b1, 1'b0, 3'b111, 1'b0, '0, 8'h22, "R8 read");
      tick(1'b1, 1'b0, 3'b000, 1'b0, '0, 8'h00, "R8 slot");
      out_en = 1'b0; #1;
      check(dout_oe === 1'b0, "R8 async off", WW'(dout_oe), '0);
      #2 out_en = 1'b1; #1;
      check(dout_oe === 1'b1, "R8 async on", WW'(dout_oe), WW'(1));
      idle(2, "R8 flush");

      // R3: constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] cs;
         cs = (($urandom() % 8) != 0) ? 3'b111 : 3'($urandom() % 7);
         out_en = (($urandom() % 5) != 0);
         tick((($urandom() % 10) != 0), (($urandom() % 10) < 3), cs, 1'($urandom()),
              LN'($urandom()), AW'($urandom()), "R3 random mix");
      end
      out_en = 1'b1;
      idle(3, "R3 final flush");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule